// File: doc/BRIEF.md
# Data Trace Access Splitter

This block takes captured processor data writes and turns them into trace requests for a downstream message generator. Each write arrives on a valid/ready input as a byte address, a size code and up to eight bytes of little-endian data. The block works out whether the bytes of the write run past a 64-bit aligned boundary. A write that stays within one doubleword produces at most one request. A write that runs past the boundary is cut into a lower part and an upper part.

Each part is filtered on its own against an inclusive address window set by two inputs, `win_lo` and `win_hi`. Every part whose starting address lies inside the window goes out on a valid/ready output, in bus order. Each request is tagged with a part flag. The lower part keeps the size code of the whole write. The upper part carries a size code that counts only the bytes past the boundary, and its data is shifted down so that its first byte sits in lane 0.

The window inputs are expected to stay steady while an access is in flight. A new write is taken only after every request of the previous one has been handed off.

Top module: `dtrace_splitter`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `in_ready` is 1. A reset that arrives while requests are pending discards them.
- R2: A write whose bytes stay inside one 64-bit aligned doubleword, with its address inside the window, gives exactly one request. That request has the same address, size code and data as the write, and `out_part` = 0.
- R3: A write that stays inside one doubleword but has its address outside the window gives no request, and `in_ready` returns to 1.
- R4: A write with (addr[2:0] + bytes) > 8 crosses the boundary. If both parts are in the window, it gives two requests. The lower part comes first, with the original address, size code and data and `out_part` = 0. The upper part comes next, at the following 8-byte aligned address, with `out_part` = 1.
- R5: Size codes are the byte count minus one (0 = 1 byte … 7 = 8 bytes). The upper part's size code is addr[2:0] + bytes − 9. Its data is the write data shifted right by 8·(8 − addr[2:0]) bits.
- R6: If only the lower part of a crossing write is in the window, only the lower request is issued.
- R7: If only the upper part of a crossing write is in the window, only the upper request is issued, with `out_part` = 1.
- R8: The window test is inclusive (`win_lo` ≤ address ≤ `win_hi`). It is applied to each part's own starting address, and a window with `win_lo` = `win_hi` admits exactly that one address.
- R9: While `out_valid` is 1 and `out_ready` is 0, the request fields stay unchanged and `out_valid` stays 1.
- R10: `in_ready` is 0 while any request of the accepted write is still undelivered. After the upper request of a write is handed off, `out_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_lo | input | ADDR_W | Lowest traced address (inclusive) |
| win_hi | input | ADDR_W | Highest traced address (inclusive) |
| in_valid | input | 1 | Captured write is present |
| in_ready | output | 1 | Block can take a write |
| in_addr | input | ADDR_W | Byte address of the write |
| in_size | input | 3 | Byte count minus one |
| in_data | input | 64 | Write data, byte 0 in bits 7:0 |
| out_valid | output | 1 | Trace request is present |
| out_ready | input | 1 | Consumer takes the request |
| out_addr | output | ADDR_W | Start address of this part |
| out_size | output | 3 | Byte count of this part minus one |
| out_data | output | 64 | Data of this part, first byte in bits 7:0 |
| out_part | output | 1 | 0 = lower or only part, 1 = upper part |

## Verification
The hardest situation to reach is a split write whose two requests are both pending while the consumer stalls. This must be seen together with the cases where the window keeps just one part, because only the address offsets and window edges decide which part survives. The vector table places writes a few bytes below a window edge, at the edge, and across it, with a one-address window among them. A directed test holds `out_ready` low over a two-part write, so that the held fields and the blocked input can be watched across both hand-offs.

// File: rtl/dtrace_splitter_pkg.sv
// Shared constants and types for the data trace access splitter.
// Assumes byte-addressed writes of at most one doubleword.
package dtrace_splitter_pkg;
    localparam int LANE_BYTES = 8;                      // boundary granule in bytes
    localparam int OFF_W      = $clog2(LANE_BYTES);     // offset bits inside a granule
    localparam int SIZE_W     = OFF_W;                  // size code: bytes minus one
    localparam int DATA_W     = LANE_BYTES * 8;         // data lanes in bits
    localparam int PARTS      = 2;                      // at most two parts per write

    typedef enum logic {
        PART_LOWER = 1'b0,
        PART_UPPER = 1'b1
    } part_e;
endpackage

// File: rtl/dtrace_boundary.sv
// Splits one write at the doubleword boundary (combinational).
// Works out whether the bytes run past the aligned boundary. It also gives the
// address, size code and shifted data of the upper part. It assumes the size
// code counts bytes minus one and that byte 0 of the data sits in bits 7:0.
module dtrace_boundary
    import dtrace_splitter_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] data,
    output logic              crosses,
    output logic [ADDR_W-1:0] upper_addr,
    output logic [SIZE_W-1:0] upper_size,
    output logic [DATA_W-1:0] upper_data
);
    localparam int SPAN_W  = OFF_W + 2;
    localparam int SHIFT_W = OFF_W + 4;

    logic [OFF_W-1:0]   offset;
    logic [SPAN_W-1:0]  span;
    logic [SPAN_W-1:0]  past_bytes;
    logic [SHIFT_W-1:0] shift_bits;

    // Byte offset of the write inside its doubleword and the end of its span.
    always_comb begin
        offset = addr[OFF_W-1:0];
        span   = SPAN_W'(offset) + SPAN_W'(size) + SPAN_W'(1);
    end

    // Boundary test and the count of bytes that land past the boundary.
    always_comb begin
        crosses    = (span > SPAN_W'(LANE_BYTES));
        past_bytes = span - SPAN_W'(LANE_BYTES);
        upper_size = crosses ? SIZE_W'(past_bytes - SPAN_W'(1)) : '0;
    end

    // Next aligned address after the write's own granule.
    always_comb begin
        upper_addr = {addr[ADDR_W-1:OFF_W] + (ADDR_W-OFF_W)'(1), {OFF_W{1'b0}}};
    end

    // Shift so that the first byte past the boundary lands in lane 0.
    always_comb begin
        shift_bits = SHIFT_W'((LANE_BYTES - int'(offset)) * 8);
        upper_data = crosses ? (data >> shift_bits) : '0;
    end
endmodule

// File: rtl/dtrace_window.sv
// Inclusive address window test (combinational).
// Assumes lo and hi are steady while an access is being judged.
module dtrace_window #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              hit
);
    // Hit when the address lies between both bounds, bounds included.
    always_comb begin
        hit = (addr >= lo) && (addr <= hi);
    end
endmodule

// File: rtl/dtrace_part_queue.sv
// Two-slot hand-off stage for the parts of one write.
// Loads both slots when a write is accepted. A slot holds its part only when
// that part passed the window. The lower slot is delivered before the upper
// one, and no new write is taken until both slots are empty.
module dtrace_part_queue
    import dtrace_splitter_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PARTS-1:0]  keep,
    input  logic [ADDR_W-1:0] part_addr [PARTS],
    input  logic [SIZE_W-1:0] part_size [PARTS],
    input  logic [DATA_W-1:0] part_data [PARTS],
    output logic              empty,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [SIZE_W-1:0] out_size,
    output logic [DATA_W-1:0] out_data,
    output logic              out_part
);
    logic [PARTS-1:0]  pend_q;
    logic [ADDR_W-1:0] addr_q [PARTS];
    logic [SIZE_W-1:0] size_q [PARTS];
    logic [DATA_W-1:0] data_q [PARTS];
    part_e             sel;
    logic              fire;

    // Lower slot wins whenever it still holds a part.
    always_comb begin
        sel       = pend_q[PART_LOWER] ? PART_LOWER : PART_UPPER;
        out_valid = |pend_q;
        empty     = ~|pend_q;
        fire      = out_valid && out_ready;
        out_addr  = addr_q[sel];
        out_size  = size_q[sel];
        out_data  = data_q[sel];
        out_part  = sel;
    end

    for (genvar g = 0; g < PARTS; g++) begin : g_slot
        // Pending flag: set on load if the part is kept, cleared on hand-off.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
            end else if (load) begin
                pend_q[g] <= keep[g];
            end else if (fire && (int'(sel) == g)) begin
                pend_q[g] <= 1'b0;
            end
        end

        // Payload capture for this part when a write is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[g] <= '0;
                size_q[g] <= '0;
                data_q[g] <= '0;
            end else if (load) begin
                addr_q[g] <= part_addr[g];
                size_q[g] <= part_size[g];
                data_q[g] <= part_data[g];
            end
        end
    end
endmodule

// File: rtl/dtrace_splitter.sv
// Data trace access splitter, top level.
// Takes one captured write per hand-off. It cuts the write at a doubleword
// boundary when needed, filters each part against an inclusive window, and
// issues the surviving parts in bus order. The window is assumed steady while
// a write is in flight.
module dtrace_splitter
    import dtrace_splitter_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] win_lo,
    input  logic [ADDR_W-1:0] win_hi,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [SIZE_W-1:0] in_size,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [SIZE_W-1:0] out_size,
    output logic [DATA_W-1:0] out_data,
    output logic              out_part
);
    logic              crosses;
    logic [ADDR_W-1:0] up_addr;
    logic [SIZE_W-1:0] up_size;
    logic [DATA_W-1:0] up_data;
    logic [ADDR_W-1:0] p_addr [PARTS];
    logic [SIZE_W-1:0] p_size [PARTS];
    logic [DATA_W-1:0] p_data [PARTS];
    logic [PARTS-1:0]  hit;
    logic [PARTS-1:0]  keep;
    logic              empty;
    logic              load;

    dtrace_boundary #(.ADDR_W(ADDR_W)) u_bound (
        .addr       (in_addr),
        .size       (in_size),
        .data       (in_data),
        .crosses    (crosses),
        .upper_addr (up_addr),
        .upper_size (up_size),
        .upper_data (up_data)
    );

    // Part payloads: the lower part keeps the whole write's fields.
    always_comb begin
        p_addr[PART_LOWER] = in_addr;
        p_size[PART_LOWER] = in_size;
        p_data[PART_LOWER] = in_data;
        p_addr[PART_UPPER] = up_addr;
        p_size[PART_UPPER] = up_size;
        p_data[PART_UPPER] = up_data;
    end

    for (genvar g = 0; g < PARTS; g++) begin : g_win
        dtrace_window #(.ADDR_W(ADDR_W)) u_win (
            .addr (p_addr[g]),
            .lo   (win_lo),
            .hi   (win_hi),
            .hit  (hit[g])
        );
    end

    // The upper part only exists for a crossing write.
    always_comb begin
        keep[PART_LOWER] = hit[PART_LOWER];
        keep[PART_UPPER] = hit[PART_UPPER] && crosses;
        in_ready         = empty;
        load             = in_valid && empty;
    end

    dtrace_part_queue #(.ADDR_W(ADDR_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .keep      (keep),
        .part_addr (p_addr),
        .part_size (p_size),
        .part_data (p_data),
        .empty     (empty),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_addr  (out_addr),
        .out_size  (out_size),
        .out_data  (out_data),
        .out_part  (out_part)
    );
endmodule

// File: rtl/dtrace_splitter_chk.sv
// Protocol and ordering checks for the splitter, attached by bind.
// Assumes the window is steady while requests are pending.
module dtrace_splitter_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] win_lo,
    input logic [ADDR_W-1:0] win_hi,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic [2:0]        out_size,
    input logic [63:0]       out_data,
    input logic              out_part
);
    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_size)
                                    && $stable(out_data) && $stable(out_part));

    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R10
    upper_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_part |=> !out_valid);

    // R8
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr >= win_lo) && (out_addr <= win_hi));

    // R5
    upper_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_part |-> (out_addr[2:0] == 3'd0) && (out_size != 3'd7));
endmodule

bind dtrace_splitter dtrace_splitter_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_lo    (win_lo),
    .win_hi    (win_hi),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_size  (out_size),
    .out_data  (out_data),
    .out_part  (out_part)
);

// File: tb/dtrace_splitter_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module dtrace_splitter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 10;
    localparam logic [63:0] WDATA = 64'h8877_6655_4433_2211;

    typedef struct packed {
        logic [31:0] addr;
        logic [2:0]  size;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [1:0]  n;
        logic [31:0] a0;
        logic [2:0]  s0;
        logic        p0;
        logic [31:0] a1;
        logic [2:0]  s1;
        logic        p1;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        // R2 and R8 (lower edge): aligned word at window start
        '{32'h1000, 3'd3, 32'h1000, 32'h1FFF, 2'd1, 32'h1000, 3'd3, 1'b0, 32'h0, 3'd0, 1'b0},
        // R3: aligned doubleword below window
        '{32'h0FF8, 3'd7, 32'h1000, 32'h1FFF, 2'd0, 32'h0, 3'd0, 1'b0, 32'h0, 3'd0, 1'b0},
        // R4 and R5: word at offset 5, both parts kept, upper is 1 byte
        '{32'h1005, 3'd3, 32'h1000, 32'h1FFF, 2'd2, 32'h1005, 3'd3, 1'b0, 32'h1008, 3'd0, 1'b1},
        // R6: upper part lands past window end
        '{32'h1FFE, 3'd3, 32'h1000, 32'h1FFF, 2'd1, 32'h1FFE, 3'd3, 1'b0, 32'h0, 3'd0, 1'b0},
        // R7: lower part below window, upper part 5 bytes at window start
        '{32'h0FFD, 3'd7, 32'h1000, 32'h1FFF, 2'd1, 32'h1000, 3'd4, 1'b1, 32'h0, 3'd0, 1'b0},
        // R8 (upper edge): single byte at window end
        '{32'h1FFF, 3'd0, 32'h1000, 32'h1FFF, 2'd1, 32'h1FFF, 3'd0, 1'b0, 32'h0, 3'd0, 1'b0},
        // R2: seven bytes ending exactly at the boundary, no split
        '{32'h1001, 3'd6, 32'h1000, 32'h1FFF, 2'd1, 32'h1001, 3'd6, 1'b0, 32'h0, 3'd0, 1'b0},
        // R4 and R5: halfword at offset 7
        '{32'h1007, 3'd1, 32'h1000, 32'h1FFF, 2'd2, 32'h1007, 3'd1, 1'b0, 32'h1008, 3'd0, 1'b1},
        // R3: aligned halfword above window
        '{32'h2000, 3'd1, 32'h1000, 32'h1FFF, 2'd0, 32'h0, 3'd0, 1'b0, 32'h0, 3'd0, 1'b0},
        // R8 and R7: one-address window admits only the upper part
        '{32'h3006, 3'd3, 32'h3008, 32'h3008, 2'd1, 32'h3008, 3'd1, 1'b1, 32'h0, 3'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] win_lo = '0;
    logic [31:0] win_hi = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic [2:0]  in_size = '0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_addr;
    logic [2:0]  out_size;
    logic [63:0] out_data;
    logic        out_part;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtrace_splitter #(.ADDR_W(32)) dut_i (
        .clk, .rst_n, .win_lo, .win_hi, .in_valid, .in_ready, .in_addr, .in_size,
        .in_data, .out_valid, .out_ready, .out_addr, .out_size, .out_data, .out_part
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] upper_data(input logic [31:0] a);
        int off = int'(a[2:0]);
        return WDATA >> (8 * (8 - off));
    endfunction

    // Present one write at a falling edge; it is taken at the next rising edge.
    task automatic send(input logic [31:0] a, input logic [2:0] s);
        in_addr  = a;
        in_size  = s;
        in_data  = WDATA;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] ga [2];
        logic [2:0]  gs [2];
        logic [63:0] gd [2];
        logic        gp [2];
        int          got;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", 64'(out_valid), 64'd0);
        check("R1 in_ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            win_lo = VECS[i].lo;
            win_hi = VECS[i].hi;
            send(VECS[i].addr, VECS[i].size);
            got = 0;
            for (int c = 0; c < 4; c++) begin
                if (out_valid) begin
                    if (got < 2) begin
                        ga[got] = out_addr; gs[got] = out_size;
                        gd[got] = out_data; gp[got] = out_part;
                    end
                    got++;
                end
                @(negedge clk);
            end
            check($sformatf("vec%0d count", i), 64'(got), 64'(VECS[i].n));
            if (VECS[i].n >= 2'd1 && got >= 1) begin
                check($sformatf("vec%0d addr0", i), 64'(ga[0]), 64'(VECS[i].a0));
                check($sformatf("vec%0d size0", i), 64'(gs[0]), 64'(VECS[i].s0));
                check($sformatf("vec%0d part0", i), 64'(gp[0]), 64'(VECS[i].p0));
                check($sformatf("vec%0d data0 R5", i), gd[0],
                      VECS[i].p0 ? upper_data(VECS[i].addr) : WDATA);
            end
            if (VECS[i].n == 2'd2 && got >= 2) begin
                check($sformatf("vec%0d addr1 R4", i), 64'(ga[1]), 64'(VECS[i].a1));
                check($sformatf("vec%0d size1 R5", i), 64'(gs[1]), 64'(VECS[i].s1));
                check($sformatf("vec%0d part1", i), 64'(gp[1]), 64'(VECS[i].p1));
                check($sformatf("vec%0d data1 R5", i), gd[1], upper_data(VECS[i].addr));
            end
            check($sformatf("vec%0d idle R3/R10", i), 64'(in_ready), 64'd1);
        end

        // R9 and R10: consumer stalls over a two-part write
        win_lo = 32'h1000; win_hi = 32'h1FFF;
        out_ready = 1'b0;
        send(32'h1006, 3'd7);
        for (int c = 0; c < 3; c++) begin
            check("R9 held valid", 64'(out_valid), 64'd1);
            check("R9 held addr", 64'(out_addr), 64'h1006);
            check("R10 input blocked", 64'(in_ready), 64'd0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R10 upper pending part", 64'(out_part), 64'd1);
        check("R10 upper pending addr", 64'(out_addr), 64'h1008);
        check("R5 upper size", 64'(out_size), 64'd5);
        check("R10 still blocked", 64'(in_ready), 64'd0);
        @(negedge clk);
        check("R9 upper held", 64'(out_addr), 64'h1008);
        out_ready = 1'b1;
        @(negedge clk);
        check("R10 drained valid", 64'(out_valid), 64'd0);
        check("R10 drained ready", 64'(in_ready), 64'd1);

        // R1: reset while a request is pending discards it
        out_ready = 1'b0;
        send(32'h1010, 3'd3);
        check("R1 pending before reset", 64'(out_valid), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears valid", 64'(out_valid), 64'd0);
        check("R1 reset ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule